// File: doc/BRIEF.md
# Level-1 Trigger Decision Controller

This block turns a vector of per-subsystem condition bits into a single level-1 accept pulse. Each condition bit first passes through its own programmable delay line, so that bits from subsystems with different processing latencies line up in the same clock cycle. The aligned vector is then compared against a small table of required-bit masks. Each table entry has a prescaler, so frequent event classes can be thinned. The lowest-numbered entry that fires sets the reported event type.

An accept is withheld while data acquisition signals busy. It is also withheld during a fixed dead window after every accept, which the front-end electronics need for peak finding. A suppressed candidate is dropped, never queued. Every accept carries an 8-bit trigger number. A check pulse marks every 256th accept, so the downstream readout can confirm that it has counted the same number of triggers. Configuration is written through a simple address/data write port. The block runs on the pipeline clock, which is derived elsewhere from the accelerator RF and is about 40 MHz.

Top module: `trig_decider`

## Requirements
- R1: While reset is low, and in the first cycle after it, `l1Accept` and `checkPulse` are 0.
- R2: Condition bit i is delayed by the value in its delay register: group 0, index i, `cfgData[5:0]`. The range is 0 to 63 cycles and the reset value is 0. With delay d, a one-cycle condition pulse presented before clock edge n is seen by the decision at edge n+d.
- R3: Table entry t lives at group 1, index t, with its mask in `cfgData[7:0]`. Entry t matches in a cycle when its mask is nonzero and every mask bit is set in the aligned condition vector. An entry whose mask is zero never matches, and all masks reset to zero.
- R4: `eventType` reports the lowest-numbered entry that passes its prescaler in the decision cycle of the accept.
- R5: The prescale value N of entry t lives at group 2, index t, in `cfgData[7:0]`. Entry t passes on every Nth cycle in which it matches, counted from reset or from the last write of its prescale value. N of 0 or 1 passes on every match. The count advances on a match even when the accept is then suppressed.
- R6: If `daqBusy` is high in the decision cycle, no accept results, and the candidate is not issued later.
- R7: Two accepts are at least BLOCK_CYCLES (120) clocks apart. A condition that keeps matching is accepted again exactly 120 clocks after the previous accept. Candidates inside the window are dropped.
- R8: An accept appears as a one-cycle high on `l1Accept`, in the cycle after the decision edge.
- R9: `trigNumber` shown with an accept equals the number of earlier accepts since reset, modulo 256. The first accept carries 0.
- R10: `checkPulse` is high only together with an accept whose `trigNumber` is 255, and it is always high with such an accept.
- R11: Group addressing uses `cfgAddr[5:4]` (0 delay, 1 mask, 2 prescale) and `cfgAddr[3:0]` as the index. A write takes effect at the clock edge where `cfgWe` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pipeline clock |
| rstN | input | 1 | Active-low asynchronous reset |
| condIn | input | NUM_COND (8) | Condition bits from the subsystems |
| daqBusy | input | 1 | Data acquisition cannot take a trigger |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 6 | Configuration group and index |
| cfgData | input | CFG_W (8) | Configuration write data |
| l1Accept | output | 1 | Level-1 accept pulse |
| eventType | output | TYPE_W (2) | Table entry that caused the accept |
| trigNumber | output | NUM_W (8) | Number of this accept, wrapping |
| checkPulse | output | 1 | Marks every 256th accept |

## Verification
A wrong delay tap shows up at the ports as an accept shifted by a fixed number of cycles, or as a missing accept when two bits fail to coincide. This is visible within one delay span of the stimulus. A dead counter that is loaded or decremented wrongly changes the spacing of accepts under a condition held high, so the spacing is measured at the first re-accept, 120 cycles on. Prescale or trigger-number counter faults only surface after several events: one prescale period, or 256 accepts for the check pulse. The bench therefore drives enough accepts to pass the 255 boundary and wrap the count.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int GRP_DELAY = 0;
  localparam int GRP_MASK  = 1;
  localparam int GRP_SCALE = 2;

  typedef struct packed {
    logic fire;
    logic wrDelay;
    logic wrMask;
    logic wrScale;
  } trigStrobe_t;
endpackage

// File: rtl/trig_delay_line.sv
module trig_delay_line #(
  parameter int MAX_DELAY = 63,
  localparam int SEL_W = $clog2(MAX_DELAY + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitIn,
  input  logic [SEL_W-1:0] delaySel,
  output logic             bitOut
);
  logic [MAX_DELAY-1:0] stages;
  logic [MAX_DELAY:0]   taps;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stages <= '0;
    else       stages <= {stages[MAX_DELAY-2:0], bitIn};
  end

  // tap 0 is the live input, tap k is the input k cycles ago
  assign taps   = {stages, bitIn};
  assign bitOut = taps[delaySel];
endmodule

// File: rtl/trig_control.sv
module trig_control
  import trig_pkg::*;
#(
  parameter int BLOCK_CYCLES = 120,
  localparam int CNT_W = $clog2(BLOCK_CYCLES + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        anyPass,
  input  logic        daqBusy,
  input  logic        cfgWe,
  input  logic [1:0]  cfgGroup,
  output trigStrobe_t strobes
);
  logic [CNT_W-1:0] deadCnt;
  logic             deadNow;
  logic             fireNow;

  assign deadNow = (deadCnt != '0);
  assign fireNow = anyPass && !daqBusy && !deadNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        deadCnt <= '0;
    else if (fireNow) deadCnt <= CNT_W'(BLOCK_CYCLES - 1);
    else if (deadNow) deadCnt <= deadCnt - 1'b1;
  end

  always_comb begin
    strobes.fire    = fireNow;
    strobes.wrDelay = cfgWe && (cfgGroup == 2'(GRP_DELAY));
    strobes.wrMask  = cfgWe && (cfgGroup == 2'(GRP_MASK));
    strobes.wrScale = cfgWe && (cfgGroup == 2'(GRP_SCALE));
  end
endmodule

// File: rtl/trig_datapath.sv
module trig_datapath
  import trig_pkg::*;
#(
  parameter int NUM_COND  = 8,
  parameter int NUM_TYPES = 4,
  parameter int MAX_DELAY = 63,
  parameter int SCALE_W   = 8,
  parameter int NUM_W     = 8,
  parameter int CFG_W     = 8,
  localparam int TYPE_W   = (NUM_TYPES > 1) ? $clog2(NUM_TYPES) : 1,
  localparam int SEL_W    = $clog2(MAX_DELAY + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_COND-1:0] condIn,
  input  logic [3:0]          cfgIdx,
  input  logic [CFG_W-1:0]    cfgData,
  input  trigStrobe_t         strobes,
  output logic                anyPass,
  output logic                l1Accept,
  output logic [TYPE_W-1:0]   eventType,
  output logic [NUM_W-1:0]    trigNumber,
  output logic                checkPulse
);
  logic [NUM_COND-1:0]  aligned;
  logic [NUM_TYPES-1:0] passVec;
  logic [TYPE_W-1:0]    typeSel;
  logic [NUM_W-1:0]     numCnt;

  // per-input delay register and delay line
  for (genvar i = 0; i < NUM_COND; i++) begin : g_in
    logic [SEL_W-1:0] delayReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) delayReg <= '0;
      else if (strobes.wrDelay && cfgIdx == 4'(i)) delayReg <= SEL_W'(cfgData);
    end

    trig_delay_line #(.MAX_DELAY(MAX_DELAY)) u_dly (
      .clk     (clk),
      .rstN    (rstN),
      .bitIn   (condIn[i]),
      .delaySel(delayReg),
      .bitOut  (aligned[i])
    );
  end

  // trigger table entries with prescalers
  for (genvar t = 0; t < NUM_TYPES; t++) begin : g_type
    logic [NUM_COND-1:0] maskReg;
    logic [SCALE_W-1:0]  scaleReg;
    logic [SCALE_W-1:0]  scaleCnt;
    logic                hit;
    logic                atLimit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        maskReg  <= '0;
        scaleReg <= '0;
      end else begin
        if (strobes.wrMask && cfgIdx == 4'(t))  maskReg  <= NUM_COND'(cfgData);
        if (strobes.wrScale && cfgIdx == 4'(t)) scaleReg <= SCALE_W'(cfgData);
      end
    end

    assign hit     = (maskReg != '0) && ((aligned & maskReg) == maskReg);
    assign atLimit = (scaleReg <= SCALE_W'(1)) || (scaleCnt == scaleReg - 1'b1);
    assign passVec[t] = hit && atLimit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) scaleCnt <= '0;
      else if (strobes.wrScale && cfgIdx == 4'(t)) scaleCnt <= '0;
      else if (hit) scaleCnt <= atLimit ? '0 : scaleCnt + 1'b1;
    end
  end

  assign anyPass = |passVec;

  always_comb begin
    typeSel = '0;
    for (int t = NUM_TYPES - 1; t >= 0; t--) begin
      if (passVec[t]) typeSel = TYPE_W'(t);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      l1Accept   <= 1'b0;
      checkPulse <= 1'b0;
      eventType  <= '0;
      trigNumber <= '0;
      numCnt     <= '0;
    end else if (strobes.fire) begin
      l1Accept   <= 1'b1;
      checkPulse <= (numCnt == '1);
      eventType  <= typeSel;
      trigNumber <= numCnt;
      numCnt     <= numCnt + 1'b1;
    end else begin
      l1Accept   <= 1'b0;
      checkPulse <= 1'b0;
    end
  end
endmodule

// File: rtl/trig_decider.sv
module trig_decider
  import trig_pkg::*;
#(
  parameter int NUM_COND     = 8,
  parameter int NUM_TYPES    = 4,
  parameter int MAX_DELAY    = 63,
  parameter int SCALE_W      = 8,
  parameter int NUM_W        = 8,
  parameter int CFG_W        = 8,
  parameter int BLOCK_CYCLES = 120,
  localparam int TYPE_W      = (NUM_TYPES > 1) ? $clog2(NUM_TYPES) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_COND-1:0] condIn,
  input  logic                daqBusy,
  input  logic                cfgWe,
  input  logic [5:0]          cfgAddr,
  input  logic [CFG_W-1:0]    cfgData,
  output logic                l1Accept,
  output logic [TYPE_W-1:0]   eventType,
  output logic [NUM_W-1:0]    trigNumber,
  output logic                checkPulse
);
  trigStrobe_t strobes;
  logic        anyPass;

  trig_control #(.BLOCK_CYCLES(BLOCK_CYCLES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .anyPass (anyPass),
    .daqBusy (daqBusy),
    .cfgWe   (cfgWe),
    .cfgGroup(cfgAddr[5:4]),
    .strobes (strobes)
  );

  trig_datapath #(
    .NUM_COND (NUM_COND),
    .NUM_TYPES(NUM_TYPES),
    .MAX_DELAY(MAX_DELAY),
    .SCALE_W  (SCALE_W),
    .NUM_W    (NUM_W),
    .CFG_W    (CFG_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .condIn    (condIn),
    .cfgIdx    (cfgAddr[3:0]),
    .cfgData   (cfgData),
    .strobes   (strobes),
    .anyPass   (anyPass),
    .l1Accept  (l1Accept),
    .eventType (eventType),
    .trigNumber(trigNumber),
    .checkPulse(checkPulse)
  );
endmodule

// File: rtl/trig_decider_chk.sv
module trig_decider_chk #(
  parameter int BLOCK_CYCLES = 120,
  parameter int NUM_W        = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             daqBusy,
  input logic             l1Accept,
  input logic [NUM_W-1:0] trigNumber,
  input logic             checkPulse
);
  localparam int GAP_W = $clog2(BLOCK_CYCLES + 2);

  logic [GAP_W-1:0] sinceL1;
  logic             seenL1;
  logic [NUM_W-1:0] modelNum;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceL1  <= '0;
      seenL1   <= 1'b0;
      modelNum <= '0;
    end else if (l1Accept) begin
      sinceL1  <= '0;
      seenL1   <= 1'b1;
      modelNum <= modelNum + 1'b1;
    end else if (sinceL1 != GAP_W'(BLOCK_CYCLES)) begin
      sinceL1 <= sinceL1 + 1'b1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> !l1Accept && !checkPulse);

  // R6
  busy_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    l1Accept |-> !$past(daqBusy));

  // R7
  dead_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (l1Accept && seenL1) |-> (sinceL1 >= GAP_W'(BLOCK_CYCLES - 1)));

  // R8
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    l1Accept |=> !l1Accept);

  // R9
  trig_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    l1Accept |-> (trigNumber == modelNum));

  // R10
  check_only_with_l1_chk: assert property (@(posedge clk) disable iff (!rstN)
    checkPulse |-> (l1Accept && trigNumber == '1));

  // R10
  check_at_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (l1Accept && trigNumber == '1) |-> checkPulse);
endmodule

bind trig_decider trig_decider_chk #(.BLOCK_CYCLES(BLOCK_CYCLES), .NUM_W(NUM_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .daqBusy   (daqBusy),
  .l1Accept  (l1Accept),
  .trigNumber(trigNumber),
  .checkPulse(checkPulse)
);

// File: tb/test_trig_decider.sv
module test_trig_decider;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] condIn = '0;
  logic       daqBusy = 1'b0;
  logic       cfgWe = 1'b0;
  logic [5:0] cfgAddr = '0;
  logic [7:0] cfgData = '0;
  logic       l1Accept;
  logic [1:0] eventType;
  logic [7:0] trigNumber;
  logic       checkPulse;

  int total = 0;
  int bad = 0;
  logic [7:0] expNum = '0;
  int chkSeen = 0;

  always #5 clk = ~clk;

  trig_decider i_trig_decider (
    .clk(clk), .rstN(rstN), .condIn(condIn), .daqBusy(daqBusy),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .l1Accept(l1Accept), .eventType(eventType),
    .trigNumber(trigNumber), .checkPulse(checkPulse)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R11: group in cfgAddr[5:4], index in cfgAddr[3:0]
  task automatic cfgWrite(input int grp, input int idx, input int val);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = {2'(grp), 4'(idx)}; cfgData = 8'(val);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // called at a sample point: numbering and check pulse of one sample
  task automatic sampleOutputs(output logic gotL1);
    gotL1 = l1Accept;
    if (checkPulse && !l1Accept) check("R10", 1, 0, "check pulse without accept");
    if (l1Accept) begin
      check("R9", int'(trigNumber), int'(expNum), "trigger number");
      check("R10", int'(checkPulse), int'(expNum == 8'hFF), "check pulse");
      if (checkPulse) chkSeen++;
      expNum = expNum + 8'd1;
    end
  endtask

  task automatic runPulse(input logic [7:0] vec, input logic busy, input int window,
                          output int firstAt, output int count, output int typ);
    logic got;
    firstAt = -1; count = 0; typ = -1;
    @(negedge clk);
    condIn = vec; daqBusy = busy;
    for (int k = 0; k < window; k++) begin
      @(negedge clk);
      sampleOutputs(got);
      if (k == 0) begin condIn = '0; daqBusy = 1'b0; end
      if (got) begin
        count++;
        if (firstAt < 0) begin firstAt = k; typ = int'(eventType); end
      end
    end
  endtask

  task automatic tReset();
    check("R1", int'(l1Accept), 0, "accept in reset");
    check("R1", int'(checkPulse), 0, "check in reset");
    rstN = 1'b1;
    @(negedge clk);
    check("R1", int'(l1Accept), 0, "accept after reset");
  endtask

  task automatic tDelay();
    int at, n, ty;
    cfgWrite(1, 0, 8'h01);
    cfgWrite(0, 0, 0);
    runPulse(8'h01, 0, 200, at, n, ty);
    check("R2", at, 0, "delay 0 offset");
    check("R8", n, 1, "single accept");
    cfgWrite(0, 0, 5);
    runPulse(8'h01, 0, 200, at, n, ty);
    check("R2", at, 5, "delay 5 offset");
    cfgWrite(0, 0, 63);
    runPulse(8'h01, 0, 200, at, n, ty);
    check("R2", at, 63, "delay 63 offset");
    check("R4", ty, 0, "type of entry 0");
    cfgWrite(0, 0, 0);
  endtask

  task automatic tAlign();
    int at, n, ty;
    cfgWrite(1, 1, 8'h06);
    cfgWrite(0, 1, 3);
    runPulse(8'h06, 0, 200, at, n, ty);
    check("R2", n, 0, "misaligned pair rejected");
    cfgWrite(0, 2, 3);
    runPulse(8'h06, 0, 200, at, n, ty);
    check("R2", at, 3, "aligned pair offset");
    check("R4", ty, 1, "aligned pair type");
    cfgWrite(0, 1, 0);
    cfgWrite(0, 2, 0);
  endtask

  task automatic tTable();
    int at, n, ty;
    runPulse(8'h07, 0, 200, at, n, ty);
    check("R4", ty, 0, "lowest entry wins");
    runPulse(8'h06, 0, 200, at, n, ty);
    check("R4", ty, 1, "entry 1 alone");
    runPulse(8'h02, 0, 200, at, n, ty);
    check("R3", n, 0, "partial mask rejected");
    runPulse(8'h10, 0, 200, at, n, ty);
    check("R3", n, 0, "zero-mask entries never match");
  endtask

  task automatic tPrescale();
    int at, n, ty;
    int expCnt[6] = '{0, 0, 1, 0, 0, 1};
    cfgWrite(1, 2, 8'h08);
    cfgWrite(2, 2, 3);
    for (int i = 0; i < 6; i++) begin
      runPulse(8'h08, 0, 130, at, n, ty);
      check("R5", n, expCnt[i], $sformatf("prescale occurrence %0d", i + 1));
      if (n == 1) check("R4", ty, 2, "prescaled type");
    end
  endtask

  task automatic tBusy();
    int at, n, ty;
    runPulse(8'h01, 1, 200, at, n, ty);
    check("R6", n, 0, "busy suppresses and drops");
    runPulse(8'h01, 0, 200, at, n, ty);
    check("R6", n, 1, "accept once busy clears");
  endtask

  task automatic tDeadDrop();
    int at, n, ty;
    runPulse(8'h01, 0, 60, at, n, ty);
    check("R7", n, 1, "first accept");
    runPulse(8'h01, 0, 200, at, n, ty);
    check("R7", n, 0, "candidate in dead window dropped");
  endtask

  task automatic tHoldWrap();
    logic got;
    int lastAt = -1;
    int seen = 0;
    int startChk = chkSeen;
    @(negedge clk);
    condIn = 8'h01;
    for (int k = 0; k < 40000 && seen < 270; k++) begin
      @(negedge clk);
      sampleOutputs(got);
      if (got) begin
        if (lastAt >= 0) check("R7", k - lastAt, 120, "held condition spacing");
        lastAt = k;
        seen++;
      end
    end
    condIn = '0;
    check("R7", seen, 270, "accepts under held condition");
    check("R10", chkSeen - startChk, 1, "one check pulse across wrap");
    check("R9", int'(expNum), 280 % 256, "count after wrap");
  endtask

  initial begin
    #(1_000_000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    tDelay();
    tAlign();
    tTable();
    tPrescale();
    tBusy();
    tDeadDrop();
    tHoldWrap();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule